// File: doc/BRIEF.md
# Programmable CAM Index Decoder

This block is the line-select stage of a direct-mapped cache whose set decoder takes three more address bits than a plain direct-mapped cache of the same size. The upper part of the index picks a fixed group of lines, and that part is decoded in the ordinary way. Inside the group, every line carries a small programmable key with a valid flag. A lookup compares the remaining index bits against every key in the group at once. A match drives a one-hot line select and a hit flag, so each access still touches exactly one line, with no way multiplexing after the array.

When the decoder misses, the cache controller reads the suggested victim line for the group being looked up. It then writes the new key bits into that line through the program port. The victim is the lowest-numbered free line if the group has one. Otherwise the victim comes from the configured policy: least-recently-used ordering, or a free-running pseudo-random count. Lines can be cleared one at a time, or all together in a single cycle. Data arrays, tag arrays and refill sequencing sit outside this block.

With the defaults there are 64 groups of 8 lines, and each line holds a 6-bit key, for 512 lines in total.

Top module: `pcam_index_decoder`

## Requirements
- R1: After reset every line is free: no lookup hits, `lk_sel` is zero, and the victim for any group is line 0.
- R2: A lookup with `lk_valid` high hits only when a valid line of group `lk_grp` holds the key `lk_ptag`. It then raises bit n of `lk_sel` (n = line number) and `lk_hit`. A different group or key misses.
- R3: `lk_sel` is one-hot or all zero, `lk_hit` is high exactly when `lk_sel` is non-zero, and both are zero while `lk_valid` is low.
- R4: A key write (`pg_wr`) takes effect at the next rising clock edge. A lookup in the same cycle as the write sees the old contents.
- R5: Writing a key into a line invalidates, on the same edge, any other valid line of that group holding the same key.
- R6: `pg_inv` frees the addressed line at the next edge. A free line never matches, whatever key it last held. `pg_inv` wins over `pg_wr` in the same cycle.
- R7: `inv_all` frees every line of every group in one cycle. It takes priority over `pg_inv` and `pg_wr` in the same cycle.
- R8: When the looked-up group has any free line, `vic_line` is the lowest-numbered free line.
- R9: With `USE_LRU`=1 and a full group, `vic_line` is the line of that group touched least recently. A key write touches the written line. A lookup hit touches the hit line, unless a key write happens in the same cycle. Before any touch, higher-numbered lines count as older.
- R10: With `USE_LRU`=0 and a full group, `vic_line` is taken from a free-running 8-bit LFSR, so it takes more than one value over 16 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_grp | input | GRP_BITS | Fixed-decoded group index of the lookup |
| lk_ptag | input | PTAG_BITS | Programmable index bits of the lookup |
| lk_sel | output | WAYS | One-hot line select within the group |
| lk_hit | output | 1 | Decoder hit |
| vic_line | output | log2(WAYS) | Suggested replacement line in group `lk_grp` |
| pg_wr | input | 1 | Write key `pg_ptag` into line `pg_line` of group `pg_grp` and mark it valid |
| pg_inv | input | 1 | Free line `pg_line` of group `pg_grp` |
| inv_all | input | 1 | Free every line |
| pg_grp | input | GRP_BITS | Group addressed by the program port |
| pg_line | input | log2(WAYS) | Line addressed by the program port |
| pg_ptag | input | PTAG_BITS | Key written by `pg_wr` |

## Verification
A corrupted valid flag or key shows up on the very next lookup of that group. It appears as a missing select bit, a select on the wrong line, or two select bits at once. Wrong replacement state shows only on `vic_line`, and only once the group has no free line. The bench therefore fills groups completely before it checks the recency order. A write that lands one edge early or late is caught by looking up in the same cycle as the write and again in the cycle after it.

// File: rtl/pcam_index_decoder.sv
module pcam_index_decoder #(
  parameter int GRP_BITS  = 6,
  parameter int WAYS      = 8,
  parameter int PTAG_BITS = 6,
  parameter bit USE_LRU   = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [GRP_BITS-1:0]      lk_grp,
  input  logic [PTAG_BITS-1:0]     lk_ptag,
  output logic [WAYS-1:0]          lk_sel,
  output logic                     lk_hit,
  output logic [$clog2(WAYS)-1:0]  vic_line,
  input  logic                     pg_wr,
  input  logic                     pg_inv,
  input  logic                     inv_all,
  input  logic [GRP_BITS-1:0]      pg_grp,
  input  logic [$clog2(WAYS)-1:0]  pg_line,
  input  logic [PTAG_BITS-1:0]     pg_ptag
);
  localparam int GROUPS   = 1 << GRP_BITS;
  localparam int WAY_BITS = $clog2(WAYS);

  logic [PTAG_BITS-1:0] key_q [GROUPS][WAYS];
  logic [WAYS-1:0]      vld_q [GROUPS];
  logic [WAYS-1:0]      grp_vld;
  logic [WAY_BITS-1:0]  hit_idx, free_idx, pol_vic;
  logic                 wr_go;

  assign grp_vld = vld_q[lk_grp];
  assign wr_go   = pg_wr & ~pg_inv & ~inv_all;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_sel[w] = lk_valid & grp_vld[w] & (key_q[lk_grp][w] == lk_ptag);
  end
  assign lk_hit = |lk_sel;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_sel[w])   hit_idx  = WAY_BITS'(w);
      if (!grp_vld[w]) free_idx = WAY_BITS'(w);
    end
  end

  assign vic_line = (&grp_vld) ? pol_vic : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < GROUPS; g++) vld_q[g] <= '0;
    end else if (inv_all) begin
      for (int g = 0; g < GROUPS; g++) vld_q[g] <= '0;
    end else if (pg_inv) begin
      vld_q[pg_grp][pg_line] <= 1'b0;
    end else if (pg_wr) begin
      for (int w = 0; w < WAYS; w++)
        if (vld_q[pg_grp][w] && key_q[pg_grp][w] == pg_ptag) vld_q[pg_grp][w] <= 1'b0;
      vld_q[pg_grp][pg_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) key_q[pg_grp][pg_line] <= pg_ptag;
  end

  if (USE_LRU) begin : g_lru
    logic [WAY_BITS-1:0] age_q [GROUPS][WAYS];
    logic [GRP_BITS-1:0] t_grp;
    logic [WAY_BITS-1:0] t_line, t_age;
    logic                t_en;

    assign t_en   = wr_go | (lk_hit & ~pg_wr);
    assign t_grp  = wr_go ? pg_grp  : lk_grp;
    assign t_line = wr_go ? pg_line : hit_idx;
    assign t_age  = age_q[t_grp][t_line];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int g = 0; g < GROUPS; g++)
          for (int w = 0; w < WAYS; w++) age_q[g][w] <= WAY_BITS'(w);
      end else if (t_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_BITS'(w) == t_line)       age_q[t_grp][w] <= '0;
          else if (age_q[t_grp][w] < t_age) age_q[t_grp][w] <= age_q[t_grp][w] + 1'b1;
        end
      end
    end

    always_comb begin
      pol_vic = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[lk_grp][w] == WAY_BITS'(WAYS - 1)) pol_vic = WAY_BITS'(w);
    end
  end else begin : g_rnd
    logic [7:0] lfsr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= 8'h01;
      else        lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end
    assign pol_vic = WAY_BITS'(lfsr_q);
  end
endmodule

module pcam_index_decoder_chk #(
  parameter int GRP_BITS  = 6,
  parameter int WAYS      = 8,
  parameter int PTAG_BITS = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    lk_valid,
  input logic [GRP_BITS-1:0]     lk_grp,
  input logic [PTAG_BITS-1:0]    lk_ptag,
  input logic [WAYS-1:0]         lk_sel,
  input logic                    lk_hit,
  input logic [$clog2(WAYS)-1:0] vic_line,
  input logic                    pg_wr,
  input logic                    pg_inv,
  input logic                    inv_all,
  input logic [GRP_BITS-1:0]     pg_grp,
  input logic [$clog2(WAYS)-1:0] pg_line,
  input logic [PTAG_BITS-1:0]    pg_ptag,
  input logic [WAYS-1:0]         grp_vld
);
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_sel) && (lk_hit == (lk_sel != '0)));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (lk_sel == '0 && !lk_hit));
  // R4
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_wr && !pg_inv && !inv_all) |=>
      (!(lk_valid && lk_grp == $past(pg_grp) && lk_ptag == $past(pg_ptag)) ||
       lk_sel[$past(pg_line)]));
  // R6
  line_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_inv && !inv_all) |=>
      (!(lk_valid && lk_grp == $past(pg_grp)) || !lk_sel[$past(pg_line)]));
  // R7
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);
  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_vld != '1) |-> !grp_vld[vic_line]);
endmodule

bind pcam_index_decoder pcam_index_decoder_chk #(
  .GRP_BITS(GRP_BITS), .WAYS(WAYS), .PTAG_BITS(PTAG_BITS)
) u_chk (.*);

// File: tb/pcam_index_decoder_bench.sv
module pcam_index_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_valid = 1'b0, pg_wr = 1'b0, pg_inv = 1'b0, inv_all = 1'b0;
  logic [5:0] lk_grp = '0, lk_ptag = '0, pg_grp = '0, pg_ptag = '0;
  logic [2:0] pg_line = '0;
  logic [7:0] lk_sel, r_sel;
  logic       lk_hit, r_hit;
  logic [2:0] vic_line, r_vic;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcam_index_decoder u_pcam_index_decoder (.*);

  pcam_index_decoder #(.USE_LRU(1'b0)) u_rnd (
    .clk, .rst_n, .lk_valid, .lk_grp, .lk_ptag, .lk_sel(r_sel), .lk_hit(r_hit),
    .vic_line(r_vic), .pg_wr, .pg_inv, .inv_all, .pg_grp, .pg_line, .pg_ptag);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(int g, int t);
    @(negedge clk);
    pg_wr = 0; pg_inv = 0; inv_all = 0;
    lk_valid = 1; lk_grp = 6'(g); lk_ptag = 6'(t);
    #1;
  endtask

  task automatic prog(int g, int l, int t);
    @(negedge clk);
    lk_valid = 0; pg_wr = 1; pg_grp = 6'(g); pg_line = 3'(l); pg_ptag = 6'(t);
    @(negedge clk);
    pg_wr = 0;
  endtask

  task automatic kill(int g, int l);
    @(negedge clk);
    lk_valid = 0; pg_inv = 1; pg_grp = 6'(g); pg_line = 3'(l);
    @(negedge clk);
    pg_inv = 0;
  endtask

  task automatic t_reset;
    look(0, 0);
    chk("R1 hit", lk_hit, 0);
    chk("R1 sel", lk_sel, 0);
    chk("R1 vic", vic_line, 0);
  endtask

  task automatic t_match;
    @(negedge clk);
    pg_wr = 1; pg_grp = 1; pg_line = 2; pg_ptag = 33;
    lk_valid = 1; lk_grp = 1; lk_ptag = 33;
    #1 chk("R4 same-cycle miss", lk_hit, 0);
    @(negedge clk);
    pg_wr = 0;
    #1 chk("R4 next-cycle sel", lk_sel, 8'h04);
    look(1, 34);
    chk("R2 other key", lk_hit, 0);
    look(2, 33);
    chk("R2 other group", lk_hit, 0);
    @(negedge clk);
    lk_valid = 0;
    #1 chk("R3 idle sel", lk_sel, 0);
  endtask

  task automatic t_dup;
    prog(1, 3, 33);
    look(1, 33);
    chk("R5 moved sel", lk_sel, 8'h08);
    chk("R3 onehot", $countones(lk_sel), 1);
    chk("R3 hit", lk_hit, 1);
  endtask

  task automatic t_inv;
    kill(1, 3);
    look(1, 33);
    chk("R6 freed line", lk_hit, 0);
    @(negedge clk);
    lk_valid = 0; pg_wr = 1; pg_inv = 1; pg_grp = 1; pg_line = 4; pg_ptag = 40;
    @(negedge clk);
    pg_wr = 0; pg_inv = 0;
    look(1, 40);
    chk("R6 inv beats write", lk_hit, 0);
  endtask

  task automatic t_victim;
    prog(2, 0, 1);
    prog(2, 1, 2);
    look(2, 63);
    chk("R8 vic", vic_line, 2);
    prog(2, 2, 3);
    kill(2, 0);
    look(2, 63);
    chk("R8 vic lowest", vic_line, 0);
  endtask

  task automatic t_lru;
    for (int i = 0; i < 8; i++) prog(5, i, 10 + i);
    look(5, 63);
    chk("R9 vic after fill", vic_line, 0);
    look(5, 10);
    chk("R9 hit line0", lk_sel, 8'h01);
    look(5, 63);
    chk("R9 vic after touch0", vic_line, 1);
    look(5, 11);
    look(5, 63);
    chk("R9 vic after touch1", vic_line, 2);
    prog(5, 2, 12);
    look(5, 63);
    chk("R9 vic after write2", vic_line, 3);
  endtask

  task automatic t_rand;
    logic [7:0] seen = '0;
    look(5, 63);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #1 seen[r_vic] = 1'b1;
    end
    chk("R10 distinct victims", int'($countones(seen) > 1), 1);
  endtask

  task automatic t_all;
    @(negedge clk);
    lk_valid = 0; inv_all = 1; pg_wr = 1; pg_grp = 3; pg_line = 0; pg_ptag = 7;
    @(negedge clk);
    inv_all = 0; pg_wr = 0;
    look(3, 7);
    chk("R7 write blocked", lk_hit, 0);
    look(5, 10);
    chk("R7 group5 cleared", lk_hit, 0);
    look(2, 2);
    chk("R7 group2 cleared", lk_hit, 0);
    chk("R7 vic free", vic_line, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_match();
    t_dup();
    t_inv();
    t_victim();
    t_lru();
    t_rand();
    t_all();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule